// File: doc/BRIEF.md
# Dual-Channel Min/Max Peak-Detect Decimator

This block captures two 10-bit parallel converter buses, sampled together from one 21-bit input word at a fixed spacing of a set number of clocks. It also drives the converter's sample clock. Each channel's field reaches the input with its bits in reverse order, so the block restores the order before it compares anything. Across each storage interval of N samples it tracks the smallest and the largest value of each channel. When an interval closes it issues a single write of a packed record to a ring buffer outside the block. It then moves the write address forward and starts the next interval. No sample is lost and the spacing does not change at that point.

A display built on these records draws one vertical bar per interval, from the minimum to the maximum. A short spike inside an interval therefore still shows up, though only one record per channel is kept. Software loads a sample period and an interval length and pulses `start`. Capture continues until `stop_in` rises. After that, `done` and `last_addr` tell the reader where the newest record sits.

Top module: `dual_peak_decim`

## Requirements
- R1: After synchronous reset the block is idle: `busy`, `done`, `wr_en`, `adc_clk` are 0 and `last_addr` is 0.
- R2: `period_cfg` (P, at least 2) and `ival_cfg` (N, at least 1) are latched when `start` is accepted while idle; later changes to them have no effect until the next accepted start.
- R3: While running, a sample is taken on the last clock of every P-clock period, so samples are exactly P clocks apart including across interval boundaries; `adc_clk` is high for the first floor(P/2) clocks of each period and low otherwise, and low while idle.
- R4: Channel A value bit k is `adc_bus[9-k]`; channel B value bit k is `adc_bus[20-k]`; `adc_bus[10]` is ignored.
- R5: Each record holds, per channel, the minimum and maximum of exactly the N samples of its interval; the first sample of an interval loads both trackers.
- R6: `wr_en` pulses for one clock, the clock after the N-th sample of an interval; `wr_data` is {maxB[39:30], minB[29:20], maxA[19:10], minA[9:0]}.
- R7: The first record after a start goes to address 0; each further record goes to the next address, wrapping from DEPTH-1 to 0.
- R8: With N = 1 every sample yields a record whose minimum equals its maximum.
- R9: A 0-to-1 change on `stop_in` while running halts capture on that clock: a sample due on that clock is discarded and no further record is written. `done` is then set and `last_addr` holds the address of the last record written. A rise while idle, or a level held high, has no effect.
- R10: `start` while running has no effect; an accepted start clears `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin capture, latching configuration |
| period_cfg | input | PER_W | Clocks per sample (P) |
| ival_cfg | input | CNT_W | Samples per storage interval (N) |
| adc_bus | input | 2*CH_W+1 | Both reversed converter fields; middle bit unused |
| stop_in | input | 1 | Capture halts on its rising edge |
| adc_clk | output | 1 | Converter sample clock |
| busy | output | 1 | Capture running |
| wr_en | output | 1 | Record write strobe |
| wr_addr | output | ADDR_W | Ring-buffer write address |
| wr_data | output | 4*CH_W | Packed min/max record |
| done | output | 1 | Capture halted by stop |
| last_addr | output | ADDR_W | Address of the most recent record |

## Verification
The bench builds the block with DEPTH = 5. A ring whose size is not a power of two then wraps within a few intervals, and the explicit wrap compare in R7 gets exercised rather than plain counter rollover. The default 10-bit fields and 8-bit counters are kept. Runs use P = 16 and N = 6, then P = 2 with N = 1, then an odd P = 5 with N = 3. In the odd-period runs the stop edge is swept across every phase, so one run halts exactly on a sample edge and the odd half-period clock shape is covered.

// File: rtl/pkd_pkg.sv
package pkd_pkg;
  typedef enum logic {RUN_IDLE, RUN_ACTIVE} run_e;

  function automatic int unsigned ring_next(int unsigned a, int unsigned depth);
    return (a == depth - 1) ? 0 : a + 1;
  endfunction
endpackage

// File: rtl/bit_unreverse.sv
module bit_unreverse #(
  parameter int W = 10
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    assign dout[k] = din[W-1-k];
  end
endmodule

// File: rtl/sample_timer.sv
module sample_timer
  import pkd_pkg::*;
#(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             halt,
  input  logic [PER_W-1:0] per_cfg,
  output logic             running,
  output logic             tick,
  output logic             smp_clk
);
  run_e             st_q;
  logic [PER_W-1:0] ph_q, per_q, ph_n;

  assign running = (st_q == RUN_ACTIVE);
  assign tick    = running && !halt && (ph_q == per_q - 1'b1);
  assign ph_n    = (ph_q == per_q - 1'b1) ? '0 : ph_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= RUN_IDLE;
      ph_q    <= '0;
      per_q   <= '0;
      smp_clk <= 1'b0;
    end else if (arm) begin
      st_q    <= RUN_ACTIVE;
      ph_q    <= '0;
      per_q   <= per_cfg;
      smp_clk <= (per_cfg >> 1) != '0;
    end else if (halt) begin
      st_q    <= RUN_IDLE;
      ph_q    <= '0;
      smp_clk <= 1'b0;
    end else if (running) begin
      ph_q    <= ph_n;
      smp_clk <= ph_n < (per_q >> 1);
    end
  end
endmodule

// File: rtl/minmax_tracker.sv
module minmax_tracker #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_en,
  input  logic         first,
  input  logic [W-1:0] sample,
  output logic [W-1:0] nxt_min,
  output logic [W-1:0] nxt_max
);
  logic [W-1:0] min_q, max_q;

  assign nxt_min = (first || sample < min_q) ? sample : min_q;
  assign nxt_max = (first || sample > max_q) ? sample : max_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      min_q <= '1;
      max_q <= '0;
    end else if (smp_en) begin
      min_q <= nxt_min;
      max_q <= nxt_max;
    end
  end
endmodule

// File: rtl/dual_peak_decim.sv
module dual_peak_decim
  import pkd_pkg::*;
#(
  parameter int CH_W   = 10,
  parameter int PER_W  = 8,
  parameter int CNT_W  = 8,
  parameter int DEPTH  = 8,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BUS_W  = 2 * CH_W + 1,
  localparam int REC_W  = 4 * CH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PER_W-1:0]  period_cfg,
  input  logic [CNT_W-1:0]  ival_cfg,
  input  logic [BUS_W-1:0]  adc_bus,
  input  logic              stop_in,
  output logic              adc_clk,
  output logic              busy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [REC_W-1:0]  wr_data,
  output logic              done,
  output logic [ADDR_W-1:0] last_addr
);
  localparam int NCH = 2;

  logic              stop_q, stop_rise, arm, halt, tick;
  logic [CNT_W-1:0]  ival_q, left_q;
  logic              first_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CH_W-1:0]   raw   [NCH];
  logic [CH_W-1:0]   val   [NCH];
  logic [CH_W-1:0]   mn    [NCH];
  logic [CH_W-1:0]   mx    [NCH];
  logic              unused_clk_slot;

  assign unused_clk_slot = adc_bus[CH_W];
  assign raw[0]    = adc_bus[CH_W-1:0];
  assign raw[1]    = adc_bus[BUS_W-1:CH_W+1];
  assign stop_rise = stop_in && !stop_q;
  assign arm       = start && !busy;
  assign halt      = busy && stop_rise;

  sample_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .arm(arm), .halt(halt), .per_cfg(period_cfg),
    .running(busy), .tick(tick), .smp_clk(adc_clk)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    bit_unreverse #(.W(CH_W)) u_rev (.din(raw[c]), .dout(val[c]));
    minmax_tracker #(.W(CH_W)) u_trk (
      .clk(clk), .rst(rst), .smp_en(tick), .first(first_q),
      .sample(val[c]), .nxt_min(mn[c]), .nxt_max(mx[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q    <= 1'b0;
      ival_q    <= '0;
      left_q    <= '0;
      first_q   <= 1'b1;
      addr_q    <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      done      <= 1'b0;
      last_addr <= '0;
    end else begin
      stop_q <= stop_in;
      wr_en  <= 1'b0;
      if (arm) begin
        ival_q  <= ival_cfg;
        left_q  <= ival_cfg;
        first_q <= 1'b1;
        addr_q  <= '0;
        done    <= 1'b0;
      end else if (halt) begin
        done <= 1'b1;
      end else if (tick) begin
        if (left_q <= 1) begin
          wr_en     <= 1'b1;
          wr_addr   <= addr_q;
          last_addr <= addr_q;
          wr_data   <= {mx[1], mn[1], mx[0], mn[0]};
          addr_q    <= ADDR_W'(ring_next(32'(addr_q), DEPTH));
          left_q    <= ival_q;
          first_q   <= 1'b1;
        end else begin
          left_q  <= left_q - 1'b1;
          first_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dual_peak_decim_chk.sv
module dual_peak_decim_chk #(
  parameter int CH_W   = 10,
  parameter int DEPTH  = 8,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              adc_clk,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [4*CH_W-1:0] wr_data,
  input logic              done
);
  AST_WR_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(busy)); // R6
  AST_ADDR_IN_RING: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (32'(wr_addr) < DEPTH)); // R7
  AST_MIN_NOT_ABOVE_MAX: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data[CH_W-1:0] <= wr_data[2*CH_W-1:CH_W]) &&
              (wr_data[3*CH_W-1:2*CH_W] <= wr_data[4*CH_W-1:3*CH_W])); // R5
  AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
  AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy)); // R9
  AST_CLK_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !adc_clk); // R3
endmodule

bind dual_peak_decim dual_peak_decim_chk #(.CH_W(CH_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .adc_clk(adc_clk),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
);

// File: tb/dual_peak_decim_tb.sv
module dual_peak_decim_tb;
  localparam int CH_W = 10, PER_W = 8, CNT_W = 8, DEPTH = 5;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst = 1, start = 0, stop_in = 0;
  logic [PER_W-1:0] period_cfg = 16;
  logic [CNT_W-1:0] ival_cfg = 6;
  logic [2*CH_W:0]  adc_bus = '0;
  logic adc_clk, busy, wr_en, done;
  logic [AW-1:0] wr_addr, last_addr;
  logic [4*CH_W-1:0] wr_data;

  int errors = 0, checks = 0;
  bit finished = 0, cfg_dirty = 0, cmp_on = 0;

  always #4 clk = ~clk;

  dual_peak_decim #(.CH_W(CH_W), .PER_W(PER_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .start(start), .period_cfg(period_cfg), .ival_cfg(ival_cfg),
    .adc_bus(adc_bus), .stop_in(stop_in), .adc_clk(adc_clk), .busy(busy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .last_addr(last_addr)
  );

  // reference model state
  int m_run, m_ph, m_per, m_ival, m_left, m_first, m_addr, m_wa, m_last;
  int m_wr, m_done, m_clk, m_stop;
  int mna, mxa, mnb, mxb;
  logic [4*CH_W-1:0] m_wd;

  function automatic int chan_val(logic [2*CH_W:0] bus, int ch);
    int v = 0;
    for (int k = 0; k < CH_W; k++)
      if (bus[(ch == 0) ? (CH_W-1-k) : (2*CH_W-k)]) v += (1 << k);
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_ph = 0; m_per = 0; m_ival = 0; m_left = 0; m_first = 1;
      m_addr = 0; m_wa = 0; m_last = 0; m_wr = 0; m_done = 0; m_clk = 0; m_stop = 0;
      m_wd = '0;
    end else begin
      automatic int rise = stop_in && !m_stop;
      m_stop = stop_in;
      m_wr = 0;
      if (!m_run) begin
        if (start) begin
          m_run = 1; m_ph = 0; m_per = period_cfg; m_ival = ival_cfg;
          m_left = ival_cfg; m_first = 1; m_addr = 0; m_done = 0;
          m_clk = (m_per / 2) > 0;
        end
      end else if (rise) begin
        m_run = 0; m_done = 1; m_clk = 0; m_ph = 0;
      end else begin
        if (m_ph == m_per - 1) begin
          automatic int a = chan_val(adc_bus, 0);
          automatic int b = chan_val(adc_bus, 1);
          if (m_first) begin mna = a; mxa = a; mnb = b; mxb = b; end
          else begin
            if (a < mna) mna = a; if (a > mxa) mxa = a;
            if (b < mnb) mnb = b; if (b > mxb) mxb = b;
          end
          if (m_left <= 1) begin
            m_wr = 1; m_wa = m_addr; m_last = m_addr;
            m_wd = {CH_W'(mxb), CH_W'(mnb), CH_W'(mxa), CH_W'(mna)};
            m_addr = (m_addr == DEPTH-1) ? 0 : m_addr + 1;
            m_left = m_ival; m_first = 1;
          end else begin
            m_left--; m_first = 0;
          end
          m_ph = 0;
        end else m_ph++;
        m_clk = m_ph < (m_per / 2);
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (cmp_on && !rst) begin
    chk(cfg_dirty ? "R2 wr_en" : "R6 wr_en", wr_en, m_wr);
    chk(cfg_dirty ? "R2 adc_clk" : "R3 adc_clk", adc_clk, m_clk);
    chk("R10 busy", busy, m_run);
    chk("R9 done", done, m_done);
    chk("R9 last_addr", last_addr, m_last);
    if (m_wr) begin
      chk("R7 wr_addr", wr_addr, m_wa);
      chk((m_ival == 1) ? "R8 data" : "R5 data", wr_data, m_wd);
    end
  end

  task automatic pulse_start(int p, int n);
    period_cfg = PER_W'(p); ival_cfg = CNT_W'(n); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic run_random(int cycles);
    for (int i = 0; i < cycles; i++) begin
      adc_bus = 21'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic do_stop();
    stop_in = 1; run_random(6); stop_in = 0; run_random(3);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 wr_en", wr_en, 0);
    chk("R1 adc_clk", adc_clk, 0); chk("R1 last_addr", last_addr, 0);
    cmp_on = 1;

    // R4 directed: bus bits 20,10,0 set -> A = 512, B = 1
    adc_bus = 21'h100401;
    pulse_start(4, 2);
    for (int i = 0; i < 40 && !wr_en; i++) @(negedge clk);
    chk("R4 record", wr_data, {10'd1, 10'd1, 10'd512, 10'd512});
    chk("R7 first addr", wr_addr, 0);
    do_stop();

    // main run P=16 N=6, config changed mid-run, extra start ignored
    pulse_start(16, 6);
    run_random(400);
    cfg_dirty = 1; period_cfg = 3; ival_cfg = 2;   // R2
    run_random(300);
    start = 1; run_random(2); start = 0;           // R10
    run_random(300);
    do_stop();
    cfg_dirty = 0;
    chk("R9 halted", busy, 0);

    // R8: N=1, P=2
    pulse_start(2, 1);
    run_random(60);
    do_stop();

    // stop rise while idle ignored, then odd period with stop swept across phases
    stop_in = 1; run_random(2); stop_in = 0; run_random(2);
    chk("R9 idle rise", busy, 0);
    for (int off = 0; off < 6; off++) begin
      pulse_start(5, 3);
      run_random(60 + off);
      do_stop();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule